// File: doc/BRIEF.md
# Receive Destination Address Screen

This block sits on the receive path of an Ethernet MAC, right after the deserializer. It sees the six destination-address bytes of each incoming frame, one byte per strobe. Each byte carries its first-received bit in bit 0. From these bytes the block decides whether the frame is for this station.

Unicast addresses are compared against a programmed 48-bit station address. A group option leaves the last four received bits of that address out of the comparison. Addresses with the group bit set are handled in one of three ways:
- The all-ones broadcast address is always taken.
- In hash mode, the frame is accepted or dropped by a 64-bit filter. The filter is indexed by six bits of a CRC-32 run over the address.
- In promiscuous-multicast mode, every multicast address is taken.

A one-cycle verdict reports accept or reject and the class of address that matched. A simple byte-wide write port loads the station address, the filter and the mode bits.

Top module: `rx_dest_screen`

## Requirements
- R1: The address class comes from bit 0 of the first address byte. A 0 means a unicast address, judged only by the station comparison. A 1 means a group address, judged by the broadcast, hash and promiscuous-multicast rules.
- R2: A unicast frame is accepted with kind 1 (station) only if all six bytes equal the programmed station bytes. Otherwise it is rejected with kind 0.
- R3: When mode bit 0 (group) is set, bits 7:4 of the sixth address byte are not compared. All other bits are still compared.
- R4: The hash CRC is run over the 48 address bits in receive order. It uses a right-shifting register preset to all ones. On each bit, if register bit 0 XOR the data bit is 1, the register is shifted right and XORed with 0xEDB88320; otherwise it is only shifted right. The filter index is register bits 5:0 after the 48th bit, with no final inversion.
- R5: Index bits 2:0 pick the filter byte and index bits 5:3 pick the bit within it. In hash mode a non-broadcast group frame is accepted with kind 2 when that filter bit is 1. When the bit is 0 the frame is rejected with kind 0.
- R6: When mode bit 1 (promiscuous multicast) is set, every group frame is accepted with kind 2 regardless of the filter. Unicast frames are still judged by R2.
- R7: The all-ones address is accepted with kind 3 in every mode, even with an all-zero filter.
- R8: verdict_vld is high for exactly one cycle: the cycle after the clock edge that captures the sixth address byte. During that cycle exactly one of accept and reject is 1. In every other cycle accept, reject and kind are 0. Idle cycles between bytes are allowed.
- R9: A start-of-frame pulse restarts byte counting and the CRC, discarding a partial address. Bytes after the sixth produce no further verdict.
- R10: A write with cfg_we high loads cfg_wdata according to cfg_sel. Selects 0 to 5 load station bytes 0 to 5, where byte 0 is the first received. Selects 6 to 13 load filter bytes 0 to 7. Select 14 loads the mode bits. Select 15 changes nothing.
- R11: After reset the outputs are 0 and the station address, filter and mode are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Start-of-frame pulse |
| byte_vld | input | 1 | Address byte strobe |
| byte_data | input | 8 | Address byte, first-received bit in bit 0 |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 4 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| verdict_vld | output | 1 | Decision valid, one cycle |
| accept | output | 1 | Frame accepted |
| reject | output | 1 | Frame rejected |
| match_kind | output | 2 | 0 none, 1 station, 2 multicast, 3 broadcast |

## Verification
The hash test programs a filter with only the bit the reference CRC selects, then the exact complement of that bit. This catches a design that swaps the byte and bit fields of the index, inverts the CRC, or feeds bits in the wrong order: it would accept the complement filter or reject the single-bit one. The group-mode test alters the upper and lower nibbles of the last byte separately. A design that masks the wrong nibble or the wrong byte would accept a true mismatch. Frames with gaps, extra trailing bytes and an aborted partial address show whether the verdict fires once, at the right cycle, and from a fresh CRC. A broadcast frame sent against an empty filter shows whether broadcast bypasses the hash.

// File: rtl/rds_pkg.sv
package rds_pkg;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET    = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    KIND_NONE    = 2'd0,
    KIND_STATION = 2'd1,
    KIND_MCAST   = 2'd2,
    KIND_BCAST   = 2'd3
  } kind_e;

  // Advance the reflected CRC by one byte, bit 0 of the byte first.
  function automatic logic [31:0] crc_byte_step(input logic [31:0] c_in,
                                                input logic [7:0]  d);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c  = {1'b0, c[31:1]};
      if (fb) c = c ^ CRC_POLY_REFL;
    end
    return c;
  endfunction
endpackage

// File: rtl/rds_cfg_regs.sv
module rds_cfg_regs #(
  parameter int ADDR_BYTES = 6,
  parameter int FILT_BYTES = 8,
  parameter int SEL_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [SEL_W-1:0]        sel,
  input  logic [7:0]              wdata,
  output logic [ADDR_BYTES*8-1:0] sta_addr,
  output logic [FILT_BYTES*8-1:0] filt_bits,
  output logic                    group_en,
  output logic                    mc_all_en
);
  localparam int FILT_BASE = ADDR_BYTES;
  localparam int MODE_SEL  = ADDR_BYTES + FILT_BYTES;

  logic [1:0] mode_q;
  logic       mode_en;

  for (genvar gi = 0; gi < ADDR_BYTES; gi++) begin : g_sta
    logic en;
    assign en = we && (sel == SEL_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sta_addr[gi*8 +: 8] <= '0;
      else if (en) sta_addr[gi*8 +: 8] <= wdata;
    end
  end

  for (genvar gf = 0; gf < FILT_BYTES; gf++) begin : g_filt
    logic en;
    assign en = we && (sel == SEL_W'(FILT_BASE + gf));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  filt_bits[gf*8 +: 8] <= '0;
      else if (en) filt_bits[gf*8 +: 8] <= wdata;
    end
  end

  assign mode_en = we && (sel == SEL_W'(MODE_SEL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= wdata[1:0];
  end

  assign group_en  = mode_q[0];
  assign mc_all_en = mode_q[1];

  // R10: a mode write shows up on the next cycle
  p_mode_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_en |=> ({mc_all_en, group_en} == $past(wdata[1:0])));
endmodule

// File: rtl/rds_crc_acc.sv
module rds_crc_acc
  import rds_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sof,
  input  logic        byte_vld,
  input  logic [7:0]  byte_data,
  output logic [31:0] crc_next
);
  logic [31:0] crc_q;
  logic [31:0] crc_base;
  logic        crc_en;

  always_comb begin
    crc_base = sof ? CRC_PRESET : crc_q;
    crc_next = byte_vld ? crc_byte_step(crc_base, byte_data) : crc_base;
    crc_en   = sof || byte_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_PRESET;
    else if (crc_en) crc_q <= crc_next;
  end

  // R4/R9: a bare start-of-frame leaves the register at the preset
  p_crc_preset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !byte_vld) |=> (crc_q == CRC_PRESET));
endmodule

// File: rtl/rds_addr_track.sv
module rds_addr_track #(
  parameter int ADDR_BYTES  = 6,
  parameter int GROUP_MASKW = 4,
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sof,
  input  logic                    byte_vld,
  input  logic [7:0]              byte_data,
  input  logic [ADDR_BYTES*8-1:0] sta_addr,
  input  logic                    group_en,
  output logic                    last_byte,
  output logic                    eq_all,
  output logic                    bc_all,
  output logic                    grp_bit
);
  logic [CNT_W-1:0] cnt_q, cnt_base, cnt_next;
  logic             eq_q, bc_q, grp_q;
  logic             eq_base, bc_base;
  logic             take, first;
  logic [7:0]       sta_byte, cmp_mask;
  logic             byte_eq;

  always_comb begin
    cnt_base = sof ? '0 : cnt_q;
    first    = (cnt_base == '0);
    take     = byte_vld && (cnt_base < CNT_W'(ADDR_BYTES));
    sta_byte = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (cnt_base == CNT_W'(i)) sta_byte = sta_addr[i*8 +: 8];
    cmp_mask = (group_en && cnt_base == CNT_W'(ADDR_BYTES - 1))
             ? (8'hFF >> GROUP_MASKW) : 8'hFF;
    byte_eq  = (((byte_data ^ sta_byte) & cmp_mask) == 8'h00);
    eq_base  = first ? 1'b1 : eq_q;
    bc_base  = first ? 1'b1 : bc_q;
    eq_all   = eq_base && byte_eq;
    bc_all   = bc_base && (byte_data == 8'hFF);
    grp_bit  = first ? byte_data[0] : grp_q;
    last_byte = take && (cnt_base == CNT_W'(ADDR_BYTES - 1));
    cnt_next = take ? cnt_base + 1'b1 : cnt_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      eq_q  <= 1'b0;
      bc_q  <= 1'b0;
      grp_q <= 1'b0;
    end else begin
      if (sof || take) cnt_q <= cnt_next;
      if (take) begin
        eq_q  <= eq_all;
        bc_q  <= bc_all;
        grp_q <= grp_bit;
      end
    end
  end

  // R9: the byte count never runs past the address length
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ADDR_BYTES));
endmodule

// File: rtl/rx_dest_screen.sv
module rx_dest_screen #(
  parameter int  ADDR_BYTES  = 6,
  parameter int  FILT_SEL_W  = 3,
  parameter int  GROUP_MASKW = 4,
  localparam int FILT_BYTES  = 1 << FILT_SEL_W,
  localparam int IDX_W       = 2 * FILT_SEL_W,
  localparam int SEL_W       = $clog2(ADDR_BYTES + FILT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             byte_vld,
  input  logic [7:0]       byte_data,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [7:0]       cfg_wdata,
  output logic             verdict_vld,
  output logic             accept,
  output logic             reject,
  output logic [1:0]       match_kind
);
  import rds_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [ADDR_BYTES*8-1:0] sta_addr;
  logic [FILT_BYTES*8-1:0] filt_bits;
  logic                    group_en, mc_all_en;
  logic [31:0]             crc_next;
  logic                    last_byte, eq_all, bc_all, grp_bit;

  rds_cfg_regs #(
    .ADDR_BYTES(ADDR_BYTES), .FILT_BYTES(FILT_BYTES), .SEL_W(SEL_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .sta_addr(sta_addr), .filt_bits(filt_bits),
    .group_en(group_en), .mc_all_en(mc_all_en)
  );

  rds_crc_acc u_crc (
    .clk(clk), .rst_n(rst_sync_n), .sof(sof), .byte_vld(byte_vld),
    .byte_data(byte_data), .crc_next(crc_next)
  );

  rds_addr_track #(
    .ADDR_BYTES(ADDR_BYTES), .GROUP_MASKW(GROUP_MASKW)
  ) u_track (
    .clk(clk), .rst_n(rst_sync_n), .sof(sof), .byte_vld(byte_vld),
    .byte_data(byte_data), .sta_addr(sta_addr), .group_en(group_en),
    .last_byte(last_byte), .eq_all(eq_all), .bc_all(bc_all),
    .grp_bit(grp_bit)
  );

  logic [IDX_W-1:0]      hidx;
  logic [FILT_SEL_W-1:0] hbyte, hbit;
  logic                  hash_hit;
  logic                  acc_d;
  kind_e                 kind_d;

  always_comb begin
    hidx     = crc_next[IDX_W-1:0];
    hbyte    = hidx[FILT_SEL_W-1:0];
    hbit     = hidx[IDX_W-1:FILT_SEL_W];
    hash_hit = filt_bits[{hbyte, hbit}];
    if (!grp_bit) begin
      acc_d  = eq_all;
      kind_d = eq_all ? KIND_STATION : KIND_NONE;
    end else if (bc_all) begin
      acc_d  = 1'b1;
      kind_d = KIND_BCAST;
    end else begin
      acc_d  = mc_all_en || hash_hit;
      kind_d = acc_d ? KIND_MCAST : KIND_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      verdict_vld <= 1'b0;
      accept      <= 1'b0;
      reject      <= 1'b0;
      match_kind  <= 2'd0;
    end else begin
      verdict_vld <= last_byte;
      accept      <= last_byte && acc_d;
      reject      <= last_byte && !acc_d;
      match_kind  <= last_byte ? kind_d : KIND_NONE;
    end
  end

  // R8: a verdict is exactly one of accept or reject
  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    verdict_vld |-> (accept ^ reject));
  // R8: outputs stay quiet outside the verdict cycle
  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !verdict_vld |-> (!accept && !reject && match_kind == 2'd0));
  // R8: a verdict always follows a byte strobe
  p_after_byte_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    verdict_vld |-> $past(byte_vld));
  // R2/R5: a reject carries no match class
  p_reject_kind_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reject |-> (match_kind == 2'd0));
endmodule

// File: tb/rx_dest_screen_bench.sv
module rx_dest_screen_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sof, byte_vld, cfg_we;
  logic [7:0] byte_data, cfg_wdata;
  logic [3:0] cfg_sel;
  logic       verdict_vld, accept, reject;
  logic [1:0] match_kind;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  rx_dest_screen u_rx_dest_screen (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
    .byte_data(byte_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .verdict_vld(verdict_vld), .accept(accept),
    .reject(reject), .match_kind(match_kind)
  );

  logic       s_vld, s_acc, s_rej;
  logic [1:0] s_kind;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_verdict(input string req, input bit exp_acc,
                               input logic [1:0] exp_kind);
    check(s_vld == 1'b1, req, "verdict_vld", 32'(s_vld), 32'd1);
    check(s_acc == exp_acc && s_rej == !exp_acc, req, "accept/reject",
          {30'd0, s_acc, s_rej}, {30'd0, exp_acc, !exp_acc});
    check(s_kind == exp_kind, req, "match_kind", 32'(s_kind), 32'(exp_kind));
  endtask

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb;
      fb = c[0] ^ a[i];
      c  = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c;
  endfunction

  task automatic cfg_write(input logic [3:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_station(input logic [47:0] a);
    for (int i = 0; i < 6; i++) cfg_write(4'(i), a[8*i +: 8]);
  endtask

  task automatic set_filter(input logic [63:0] f);
    for (int i = 0; i < 8; i++) cfg_write(4'(6 + i), f[8*i +: 8]);
  endtask

  // Sends an address (byte 0 = a[7:0]); samples the verdict after byte six.
  task automatic send(input logic [47:0] a, input int nbytes, input bit gap);
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    s_vld = 0; s_acc = 0; s_rej = 0; s_kind = 0;
    for (int i = 0; i < nbytes; i++) begin
      byte_vld  = 1'b1;
      byte_data = (i < 6) ? a[8*i +: 8] : 8'hA5;
      @(negedge clk);
      if (i == 5) begin
        s_vld = verdict_vld; s_acc = accept; s_rej = reject; s_kind = match_kind;
      end else begin
        check(verdict_vld == 1'b0, (i > 5) ? "R9" : "R8", "no early/extra verdict",
              32'(verdict_vld), 32'd0);
      end
      if (gap) begin
        byte_vld = 1'b0;
        @(negedge clk);
      end
    end
    byte_vld = 1'b0;
    @(negedge clk);
    check(verdict_vld == 1'b0 && accept == 1'b0 && reject == 1'b0, "R8",
          "verdict lasts one cycle", {30'd0, accept, reject}, 32'd0);
  endtask

  localparam logic [47:0] STA  = 48'h5A_44_33_22_11_02; // first byte 0x02
  localparam logic [47:0] MC_A = 48'hFB_00_00_5E_00_01;
  localparam logic [47:0] MC_B = 48'h01_00_00_00_33_33;
  localparam logic [47:0] BC   = 48'hFFFF_FFFF_FFFF;

  task automatic t_reset;
    check(verdict_vld == 0 && accept == 0 && reject == 0 && match_kind == 0,
          "R11", "outputs after reset", {28'd0, verdict_vld, accept, reject, 1'b0}, 32'd0);
    send(48'h0, 6, 0);
    check_verdict("R11", 1'b1, 2'd1);     // zero station equals zero address
    send(MC_A, 6, 0);
    check_verdict("R11", 1'b0, 2'd0);     // empty filter, mode zero
  endtask

  task automatic t_station;
    set_station(STA);
    send(STA, 6, 0);
    check_verdict("R2", 1'b1, 2'd1);
    send(STA ^ (48'h1 << 25), 6, 0);
    check_verdict("R2", 1'b0, 2'd0);
    send(STA ^ (48'h3 << 44), 6, 0);      // upper nibble of sixth byte
    check_verdict("R3", 1'b0, 2'd0);
    cfg_write(4'd14, 8'h01);
    send(STA ^ (48'hF << 44), 6, 0);
    check_verdict("R3", 1'b1, 2'd1);
    send(STA ^ (48'h1 << 40), 6, 0);      // lower nibble still compared
    check_verdict("R3", 1'b0, 2'd0);
    send(STA ^ (48'h1 << 36), 6, 0);      // fifth byte not masked
    check_verdict("R3", 1'b0, 2'd0);
    cfg_write(4'd14, 8'h00);
    send(STA | 48'h1, 6, 0);              // group bit set: not a station match
    check_verdict("R1", 1'b0, 2'd0);
  endtask

  task automatic t_hash(input logic [47:0] a);
    logic [31:0] c;
    logic [5:0]  idx;
    logic [63:0] one;
    c   = ref_crc(a);
    idx = c[5:0];
    one = 64'h1 << {idx[2:0], 3'b000} << idx[5:3];
    set_filter(one);
    send(a, 6, 0);
    check_verdict("R4", 1'b1, 2'd2);
    set_filter(~one);
    send(a, 6, 0);
    check_verdict("R5", 1'b0, 2'd0);
    set_filter(64'h0);
  endtask

  task automatic t_bcast;
    send(BC, 6, 0);
    check_verdict("R7", 1'b1, 2'd3);
    cfg_write(4'd14, 8'h03);
    send(BC, 6, 0);
    check_verdict("R7", 1'b1, 2'd3);
    cfg_write(4'd14, 8'h00);
  endtask

  task automatic t_mc_all;
    cfg_write(4'd14, 8'h02);
    send(MC_B, 6, 0);
    check_verdict("R6", 1'b1, 2'd2);
    send(STA ^ 48'h0100, 6, 0);
    check_verdict("R6", 1'b0, 2'd0);
    cfg_write(4'd14, 8'h00);
    send(MC_B, 6, 0);
    check_verdict("R6", 1'b0, 2'd0);
  endtask

  task automatic t_framing;
    send(STA, 6, 1);
    check_verdict("R8", 1'b1, 2'd1);
    send(STA, 9, 0);
    check_verdict("R9", 1'b1, 2'd1);
    // partial multicast aborted by a new start of frame
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    for (int i = 0; i < 3; i++) begin
      byte_vld = 1'b1; byte_data = MC_A[8*i +: 8];
      @(negedge clk);
    end
    byte_vld = 1'b0;
    send(STA, 6, 0);
    check_verdict("R9", 1'b1, 2'd1);
    // hash after an aborted frame needs a fresh CRC
    begin
      logic [31:0] c;
      c = ref_crc(MC_B);
      set_filter(64'h1 << {c[2:0], 3'b000} << c[5:3]);
      @(negedge clk); sof = 1'b1;
      @(negedge clk); sof = 1'b0;
      byte_vld = 1'b1; byte_data = 8'h77;
      @(negedge clk); byte_vld = 1'b0;
      send(MC_B, 6, 0);
      check_verdict("R9", 1'b1, 2'd2);
      set_filter(64'h0);
    end
  endtask

  task automatic t_bad_sel;
    cfg_write(4'd15, 8'hFF);
    send(STA, 6, 0);
    check_verdict("R10", 1'b1, 2'd1);
    send(MC_A, 6, 0);
    check_verdict("R10", 1'b0, 2'd0);
  endtask

  initial begin
    rst_n = 1'b0; sof = 0; byte_vld = 0; byte_data = 0;
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_station();
    t_hash(MC_A);
    t_hash(MC_B);
    t_bcast();
    t_mc_all();
    t_framing();
    t_bad_sel();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule